// File: doc/BRIEF.md
# Two-Carrier Multilevel PWM Gate Generator

This block drives the eight gates of a single-phase bridge made of two diode-clamped legs, each with four series switches. It runs a pair of triangular carriers that never reach zero. One rises and falls above zero, and the other is its exact mirror below zero. It also forms two sinusoidal references of equal size that are half a cycle apart. Each leg compares its own reference against both carriers. The result is one of three leg states, which the block expands into four gate bits with complementary lower switches and a programmable dead band on every pair.

The carrier shape is fixed by parameters: the offset `C_OFS` and the sweep `C_AMP`, so the positive peak is `PEAK = C_OFS + C_AMP`. The sweep rate is set by `period_cfg` alone, so the switching frequency changes while the carrier levels stay the same. The references step through a computed sine table of `2**PH_W` points, one point per full carrier period. The output fundamental is therefore the carrier frequency divided by the table length. In use, the table length and the clock are picked so that this gives the mains frequency. The modulation depth is set by `amp_cfg`. While `en` is low the block holds every gate off and restarts its sequence.

Top module: `dualcarrier_pwm`

## Requirements
- R1: While `rst_n` is low, all gates and `phase_idx` are 0. A rising edge sampled with `en` low clears the gates and `phase_idx` to 0 after that edge and restarts the carrier at its low point, counting upward.
- R2: The positive carrier starts at `C_OFS` after enable. It moves by one count each time `period_cfg+1` enabled clocks have elapsed, climbing to `PEAK` and then falling back to `C_OFS`. The negative carrier is its negation, so neither carrier is ever zero.
- R3: `phase_idx` increments by one, modulo `2**PH_W`, each time the positive carrier returns to `C_OFS`. Once running, successive changes are `2*C_AMP*(period_cfg+1)` clocks apart.
- R4: With H = `2**(PH_W-1)`, x = `phase_idx mod H` and p = x*(H-x), the reference magnitude is floor(A*floor(16*p*2**MAG_B/(5*H*H-4*p))/2**MAG_B). A is `amp_cfg` saturated to `PEAK-1`. Reference 1 is positive for `phase_idx < H` and negative otherwise. Reference 2 is the negation of reference 1.
- R5: A leg is in the high state when its reference exceeds the positive carrier. It is in the middle state when the reference is at or below the positive carrier but above the negative carrier. Otherwise it is in the low state. Leg 1 uses reference 1 and drives `gate[3:0]`. Leg 2 uses reference 2 and drives `gate[7:4]`.
- R6: Within a leg, bit 0 is the outer upper switch (on only in the high state) and bit 1 is the inner upper switch (on in the high and middle states). Bits 2 and 3 are the lower switches paired with bits 0 and 1. Once settled, a lower switch is the complement of its pair, and the two switches of a pair are never on together.
- R7: A pair's demanded state is sampled at each rising edge. At the edge where it differs from the state the pair last adopted, both gates of the pair go low. They remain low for the next `dead_cfg` edges and take the new state at the following edge. A change during this wait restarts it.
- R8: With `amp_cfg` = 0, both legs sit in the middle state. After enable from the cleared state, `gate` reads 8'h44 for `dead_cfg+1` cycles and then 8'h66.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces gates off and restarts the sequence |
| period_cfg | input | DIV_W | Enabled clocks per carrier step, minus one |
| amp_cfg | input | AMP_W | Reference amplitude, saturated to PEAK-1 |
| dead_cfg | input | DT_W | Extra all-off cycles after a pair changes state |
| gate | output | 8 | Gate drives: [0] outer upper, [1] inner upper, [2] outer lower, [3] inner lower of leg 1; [7:4] the same for leg 2 |
| phase_idx | output | PH_W | Current reference table point |

## Verification
A wrong carrier count or a wrong step interval moves the comparator crossings. The error then shows up as a gate edge that lands on a different clock, within one carrier step of the fault. A wrong reference sample or a wrong saturation changes pulse widths during the table point where it happens. A wrong phase count shows at `phase_idx` immediately and at the gates within one carrier period. A dead-band counter that is stuck or reloaded wrongly shows up as a pair driven too early or too late, within `dead_cfg+2` cycles of the change. The bench compares every gate bit against its own model on every clock, so each of these shows up in the cycle it first reaches the pins.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

   typedef enum logic [1:0] {
      LEG_LOW  = 2'd0,
      LEG_MID  = 2'd1,
      LEG_HIGH = 2'd2
   } leg_lvl_e;

   // Rational half-sine approximation, scaled so the crest equals 2**mb.
   function automatic int unsigned sine_mag(int unsigned x, int unsigned h, int unsigned mb);
      int unsigned p;
      int unsigned num;
      int unsigned den;
      p   = x * (h - x);
      num = (16 * p) << mb;
      den = 5 * h * h - 4 * p;
      return num / den;
   endfunction

endpackage

// File: rtl/dcp_carrier.sv
module dcp_carrier #(
   parameter int C_AMP = 200,
   parameter int C_OFS = 20,
   parameter int DIV_W = 8,
   parameter int PH_W  = 5,
   parameter int VW    = 9
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic [DIV_W-1:0]     period_cfg,
   output logic signed [VW-1:0] car_pos,
   output logic signed [VW-1:0] car_neg,
   output logic [PH_W-1:0]      phase
);
   localparam int TW = $clog2(C_AMP + 1);

   logic [DIV_W-1:0] pre_q;
   logic [TW-1:0]    tri_q;
   logic             down_q;
   logic [PH_W-1:0]  phase_q;
   logic [VW-1:0]    pos_u;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q   <= '0;
         tri_q   <= '0;
         down_q  <= 1'b0;
         phase_q <= '0;
      end else if (!en) begin
         pre_q   <= '0;
         tri_q   <= '0;
         down_q  <= 1'b0;
         phase_q <= '0;
      end else if (pre_q >= period_cfg) begin
         pre_q <= '0;
         if (!down_q) begin
            tri_q <= tri_q + 1'b1;
            if (tri_q == TW'(C_AMP - 1)) down_q <= 1'b1;
         end else begin
            tri_q <= tri_q - 1'b1;
            if (tri_q == TW'(1)) begin
               down_q  <= 1'b0;
               phase_q <= phase_q + 1'b1;
            end
         end
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   assign pos_u   = VW'(C_OFS) + VW'(tri_q);
   assign car_pos = $signed(pos_u);
   assign car_neg = -car_pos;
   assign phase   = phase_q;

endmodule

// File: rtl/dcp_reference.sv
module dcp_reference #(
   parameter int PH_W  = 5,
   parameter int MAG_B = 8,
   parameter int AMP_W = 8,
   parameter int VW    = 9,
   parameter int PEAK  = 220
) (
   input  logic [PH_W-1:0]      phase,
   input  logic [AMP_W-1:0]     amp_cfg,
   output logic signed [VW-1:0] ref_a,
   output logic signed [VW-1:0] ref_b
);
   localparam int H   = 1 << (PH_W - 1);
   localparam int LIM = PEAK - 1;
   localparam int PW  = AMP_W + MAG_B + 1;

   logic [MAG_B:0]    tab [H];
   logic [AMP_W-1:0]  amp_eff;
   logic [PW-1:0]     prod;
   logic [VW-1:0]     mag_v;

   for (genvar g = 0; g < H; g++) begin : g_tab
      assign tab[g] = (MAG_B + 1)'(dcp_pkg::sine_mag(g, H, MAG_B));
   end

   always_comb begin
      if (32'(amp_cfg) > 32'(LIM)) amp_eff = AMP_W'(LIM);
      else                         amp_eff = amp_cfg;
   end

   assign prod  = PW'(amp_eff) * PW'(tab[phase[PH_W-2:0]]);
   assign mag_v = VW'(prod >> MAG_B);
   assign ref_a = phase[PH_W-1] ? -$signed(mag_v) : $signed(mag_v);
   assign ref_b = -ref_a;

endmodule

// File: rtl/dcp_leg_cmp.sv
module dcp_leg_cmp #(
   parameter int VW = 9
) (
   input  logic signed [VW-1:0] ref_v,
   input  logic signed [VW-1:0] car_pos,
   input  logic signed [VW-1:0] car_neg,
   output logic                 dem_outer,
   output logic                 dem_inner
);
   import dcp_pkg::*;

   leg_lvl_e lvl;

   always_comb begin
      if (ref_v > car_pos)      lvl = LEG_HIGH;
      else if (ref_v > car_neg) lvl = LEG_MID;
      else                      lvl = LEG_LOW;
   end

   assign dem_outer = (lvl == LEG_HIGH);
   assign dem_inner = (lvl != LEG_LOW);

endmodule

// File: rtl/dcp_deadband.sv
module dcp_deadband #(
   parameter int DT_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [DT_W-1:0] dead_cfg,
   input  logic            demand,
   output logic            hi,
   output logic            lo
);
   logic            dem_q;
   logic [DT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dem_q <= 1'b0;
         cnt_q <= '0;
         hi    <= 1'b0;
         lo    <= 1'b0;
      end else if (!en) begin
         dem_q <= 1'b0;
         cnt_q <= '0;
         hi    <= 1'b0;
         lo    <= 1'b0;
      end else if (demand != dem_q) begin
         dem_q <= demand;
         cnt_q <= dead_cfg;
         hi    <= 1'b0;
         lo    <= 1'b0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
         hi    <= 1'b0;
         lo    <= 1'b0;
      end else begin
         hi <= dem_q;
         lo <= ~dem_q;
      end
   end

endmodule

// File: rtl/dualcarrier_pwm.sv
module dualcarrier_pwm #(
   parameter int C_AMP = 200,
   parameter int C_OFS = 20,
   parameter int DIV_W = 8,
   parameter int AMP_W = 8,
   parameter int PH_W  = 5,
   parameter int MAG_B = 8,
   parameter int DT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [DIV_W-1:0]  period_cfg,
   input  logic [AMP_W-1:0]  amp_cfg,
   input  logic [DT_W-1:0]   dead_cfg,
   output logic [7:0]        gate,
   output logic [PH_W-1:0]   phase_idx
);
   localparam int PEAK = C_OFS + C_AMP;
   localparam int VW   = $clog2(PEAK + 1) + 1;
   localparam int LEGS = 2;

   if (C_OFS < 1) begin : g_bad_ofs
      $error("carrier offset must be at least one count");
   end
   if (C_AMP < 2) begin : g_bad_amp
      $error("carrier sweep must be at least two counts");
   end
   if (PH_W < 2) begin : g_bad_ph
      $error("phase index needs at least two bits");
   end
   if (DT_W < 1 || DIV_W < 1) begin : g_bad_w
      $error("dead-band and divider widths must be positive");
   end

   logic signed [VW-1:0] car_pos;
   logic signed [VW-1:0] car_neg;
   logic signed [VW-1:0] ref_a;
   logic signed [VW-1:0] ref_b;
   logic signed [VW-1:0] ref_leg [LEGS];
   logic                 dem_u [2*LEGS];
   logic                 hi_u  [2*LEGS];
   logic                 lo_u  [2*LEGS];

   dcp_carrier #(
      .C_AMP(C_AMP), .C_OFS(C_OFS), .DIV_W(DIV_W), .PH_W(PH_W), .VW(VW)
   ) u_car (
      .clk(clk), .rst_n(rst_n), .en(en), .period_cfg(period_cfg),
      .car_pos(car_pos), .car_neg(car_neg), .phase(phase_idx)
   );

   dcp_reference #(
      .PH_W(PH_W), .MAG_B(MAG_B), .AMP_W(AMP_W), .VW(VW), .PEAK(PEAK)
   ) u_ref (
      .phase(phase_idx), .amp_cfg(amp_cfg), .ref_a(ref_a), .ref_b(ref_b)
   );

   assign ref_leg[0] = ref_a;
   assign ref_leg[1] = ref_b;

   for (genvar g = 0; g < LEGS; g++) begin : g_leg
      dcp_leg_cmp #(.VW(VW)) u_cmp (
         .ref_v(ref_leg[g]), .car_pos(car_pos), .car_neg(car_neg),
         .dem_outer(dem_u[2*g]), .dem_inner(dem_u[2*g+1])
      );
      for (genvar s = 0; s < 2; s++) begin : g_pair
         dcp_deadband #(.DT_W(DT_W)) u_db (
            .clk(clk), .rst_n(rst_n), .en(en), .dead_cfg(dead_cfg),
            .demand(dem_u[2*g+s]), .hi(hi_u[2*g+s]), .lo(lo_u[2*g+s])
         );
      end
   end

   assign gate = {lo_u[3], lo_u[2], hi_u[3], hi_u[2],
                  lo_u[1], lo_u[0], hi_u[1], hi_u[0]};

endmodule

// File: rtl/dcp_checker.sv
module dcp_checker #(
   parameter int C_AMP = 200,
   parameter int C_OFS = 20,
   parameter int PH_W  = 5,
   parameter int VW    = 9
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 en,
   input logic [7:0]           gate,
   input logic [PH_W-1:0]      phase_idx,
   input logic signed [VW-1:0] car_pos,
   input logic signed [VW-1:0] car_neg
);
   assert_gates_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (gate == 8'h00));

   assert_phase_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (phase_idx == '0));

   assert_pos_carrier_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (car_pos >= C_OFS) && (car_pos <= C_OFS + C_AMP));

   assert_neg_carrier_R2: assert property (@(posedge clk) disable iff (!rst_n)
      car_neg < 0);

   assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_idx != $past(phase_idx)) |->
      ((phase_idx == PH_W'($past(phase_idx) + 1'b1)) || (phase_idx == '0)));

   assert_pair_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate[0] && gate[2]) && !(gate[1] && gate[3]) &&
      !(gate[4] && gate[6]) && !(gate[5] && gate[7]));

   assert_gap_l1o_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate[0]) |-> !$past(gate[2]));

   assert_gap_l1i_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate[3]) |-> !$past(gate[1]));

   assert_gap_l2o_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate[6]) |-> !$past(gate[4]));

   assert_gap_l2i_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate[5]) |-> !$past(gate[7]));

endmodule

bind dualcarrier_pwm dcp_checker #(
   .C_AMP(C_AMP), .C_OFS(C_OFS), .PH_W(PH_W), .VW(VW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .gate(gate), .phase_idx(phase_idx),
   .car_pos(car_pos), .car_neg(car_neg)
);

// File: tb/sim_dualcarrier_pwm.sv
module sim_dualcarrier_pwm;
   localparam int C_AMP = 200;
   localparam int C_OFS = 20;
   localparam int PEAK  = C_OFS + C_AMP;
   localparam int H     = 16;
   localparam int NPH   = 32;
   localparam int MB    = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [7:0] period_cfg = '0;
   logic [7:0] amp_cfg = '0;
   logic [3:0] dead_cfg = '0;
   wire  [7:0] gate;
   wire  [4:0] phase_idx;

   always #2 clk = ~clk;

   dualcarrier_pwm u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .period_cfg(period_cfg),
      .amp_cfg(amp_cfg), .dead_cfg(dead_cfg), .gate(gate), .phase_idx(phase_idx)
   );

   int checks = 0;
   int errors = 0;
   bit cmp_on = 1'b0;
   bit iv_on = 1'b0;
   bit have_last = 1'b0;
   int exp_iv = 0;
   int cyc = 0;
   int last_cyc = 0;
   int last_ph = 0;
   int ph_changes = 0;
   int overlaps = 0;

   int m_pre = 0, m_tri = 0, m_down = 0, m_ph = 0;
   int dq[4], cnt[4], mh[4], ml[4];

   function automatic int smag(int x);
      int p;
      p = x * (H - x);
      return ((16 * p) << MB) / (5 * H * H - 4 * p);
   endfunction

   function automatic int leg_level(int r, int cp);
      if (r > cp) return 2;
      if (r > -cp) return 1;
      return 0;
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Behavioural model, one step per rising edge.
   always @(posedge clk) begin
      if (!rst_n || !en) begin
         m_pre = 0; m_tri = 0; m_down = 0; m_ph = 0;
         for (int i = 0; i < 4; i++) begin
            dq[i] = 0; cnt[i] = 0; mh[i] = 0; ml[i] = 0;
         end
      end else begin
         int aeff, mag, r1, cp, l1, l2;
         int dem[4];
         aeff = (int'(amp_cfg) > PEAK - 1) ? PEAK - 1 : int'(amp_cfg);
         mag  = (aeff * smag(m_ph % H)) >> MB;
         r1   = (m_ph >= H) ? -mag : mag;
         cp   = C_OFS + m_tri;
         l1   = leg_level(r1, cp);
         l2   = leg_level(-r1, cp);
         dem[0] = (l1 == 2); dem[1] = (l1 >= 1);
         dem[2] = (l2 == 2); dem[3] = (l2 >= 1);
         for (int i = 0; i < 4; i++) begin
            if (dem[i] != dq[i]) begin
               dq[i] = dem[i]; cnt[i] = int'(dead_cfg); mh[i] = 0; ml[i] = 0;
            end else if (cnt[i] != 0) begin
               cnt[i] = cnt[i] - 1; mh[i] = 0; ml[i] = 0;
            end else begin
               mh[i] = dq[i]; ml[i] = 1 - dq[i];
            end
         end
         if (m_pre >= int'(period_cfg)) begin
            m_pre = 0;
            if (m_down == 0) begin
               m_tri++;
               if (m_tri == C_AMP) m_down = 1;
            end else begin
               m_tri--;
               if (m_tri == 0) begin
                  m_down = 0;
                  m_ph = (m_ph + 1) % NPH;
               end
            end
         end else begin
            m_pre++;
         end
      end
   end

   function automatic logic [7:0] exp_gate();
      return {ml[3][0], ml[2][0], mh[3][0], mh[2][0],
              ml[1][0], ml[0][0], mh[1][0], mh[0][0]};
   endfunction

   always @(negedge clk) begin
      cyc++;
      if (cmp_on) begin
         // R2 R4 R5 R6 R7: every gate bit against the model
         chk(gate === exp_gate(), "R5 gate vs model (R2 R4 R6 R7)", int'(gate), int'(exp_gate()));
         if ((gate[0] & gate[2]) | (gate[1] & gate[3]) | (gate[4] & gate[6]) | (gate[5] & gate[7]))
            overlaps++;
      end
      if (iv_on && int'(phase_idx) != last_ph) begin
         ph_changes++;
         if (have_last) begin
            chk(cyc - last_cyc == exp_iv, "R3 phase interval", cyc - last_cyc, exp_iv);
            chk(int'(phase_idx) == (last_ph + 1) % NPH, "R3 phase step", int'(phase_idx), (last_ph + 1) % NPH);
         end
         have_last = 1'b1;
         last_cyc = cyc;
      end
      last_ph = int'(phase_idx);
   end

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(gate == 8'h00, "R1 gates in reset", int'(gate), 0);
      chk(phase_idx == 5'd0, "R1 phase in reset", int'(phase_idx), 0);
      rst_n = 1'b1;
      cmp_on = 1'b1;

      // Run 1: fastest carrier, deep modulation, short dead band.
      period_cfg = 8'd0; amp_cfg = 8'd200; dead_cfg = 4'd3;
      exp_iv = 2 * C_AMP * 1; iv_on = 1'b1; have_last = 1'b0;
      en = 1'b1;
      repeat (25600) @(negedge clk);
      chk(ph_changes >= 60, "R3 phase advance count", ph_changes, 60);

      // Disable clears everything.
      en = 1'b0; iv_on = 1'b0;
      @(negedge clk);
      chk(gate == 8'h00, "R1 gates after disable", int'(gate), 0);
      chk(phase_idx == 5'd0, "R1 phase after disable", int'(phase_idx), 0);

      // Run 2: half speed, amplitude above the clamp, no dead band.
      period_cfg = 8'd1; amp_cfg = 8'd255; dead_cfg = 4'd0;
      exp_iv = 2 * C_AMP * 2; have_last = 1'b0; iv_on = 1'b1;
      en = 1'b1;
      repeat (25700) @(negedge clk);

      // Run 3: zero amplitude, long dead band.
      en = 1'b0; iv_on = 1'b0;
      @(negedge clk);
      amp_cfg = 8'd0; dead_cfg = 4'd15; period_cfg = 8'd0;
      en = 1'b1;
      repeat (16) @(negedge clk);
      chk(gate == 8'h44, "R7 inner pairs still in dead band", int'(gate), 8'h44);
      @(negedge clk);
      chk(gate == 8'h66, "R8 middle state after dead band", int'(gate), 8'h66);
      repeat (200) @(negedge clk);
      chk(gate == 8'h66, "R8 middle state holds", int'(gate), 8'h66);

      // Run 4: live change of amplitude and period.
      amp_cfg = 8'd120; period_cfg = 8'd2; dead_cfg = 4'd7;
      exp_iv = 2 * C_AMP * 3; have_last = 1'b0; iv_on = 1'b1;
      repeat (15000) @(negedge clk);

      chk(overlaps == 0, "R6 pair overlap cycles", overlaps, 0);
      finish_run();
   end
endmodule